// File: doc/BRIEF.md
# Sixteen-bit up-counting timer with atomic byte access

This block is a 16-bit up-counter for a small controller whose CPU bus is 8 bits wide. A 3-bit source-select input decides what makes the counter advance. It can be halted. It can step on every system clock or on one of four slower rates taken from a free-running divider. It can also step on the falling or the rising edge of an external count pin, after that pin has been synchronized. The pin is sampled whatever drives it, so software that toggles the pin can step the counter.

The CPU reaches the count through a pair of byte addresses. A single shared holding byte makes every 16-bit transfer atomic. Software writes the upper byte first, and that byte waits in the holding register. The lower-byte write then commits all sixteen bits in one cycle. For a read, software reads the lower byte first. That read freezes the matching upper byte into the holding register, and the later upper-byte read returns the frozen value. The same holding byte also serves a 16-bit compare register kept in this block and a 16-bit capture value supplied from outside. When the count rolls over from 0xFFFF, a one-cycle overflow pulse is raised.

Top module: `tmr16_core`

## Requirements
- R1: After reset the count, the compare value and the holding byte are all zero, and the overflow output is low.
- R2: With source select 3'b000 the count does not change unless the CPU writes it.
- R3: Source selects 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 step the count once every 1, 8, 64, 256 and 1024 clocks. The step comes from a 10-bit divider that is cleared by reset and advances every clock. The count steps at a clock edge at which the divider's low 0, 3, 6, 8 or 10 bits are all ones.
- R4: Source select 3'b111 steps the count on each rising edge of the external pin, and 3'b110 steps it on each falling edge. The pin passes through two synchronizing flops, and each edge is counted once, at the third clock edge after the pin changes.
- R5: A write to any upper-byte address (1 counter, 3 compare, 5 capture) loads only the holding byte. It leaves the count and the compare value unchanged.
- R6: A write to address 0 loads the count with {holding byte, write data} in one cycle. A write to address 2 loads the compare value the same way. Writes to addresses 4, 6 and 7 have no effect.
- R7: A read of a lower-byte address (0 counter, 2 compare, 4 capture) returns the live low byte and copies that register's live high byte into the holding byte. A read of any upper-byte address returns the holding byte. Addresses 6 and 7, and any cycle without a read strobe, read as zero.
- R8: There is one holding byte for all three registers. A read of address 0 followed by a read of address 3 returns the counter's high byte.
- R9: When a CPU write to address 0 and a step fall in the same cycle, the written value is kept and the step is lost.
- R10: A step from 0xFFFF gives 0x0000. The overflow output is high for exactly the one cycle in which the count first shows 0x0000 after such a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Count source select |
| ext_pin | input | 1 | External count pin, asynchronous |
| bus_addr | input | 3 | CPU byte address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data, combinational |
| cap_val | input | 16 | Capture value supplied from outside |
| count | output | 16 | Current count |
| cmp_val | output | 16 | Compare register value |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
A divider phase that is off shows up at the count output within one period of the selected rate: the step lands a cycle early or late. A stale or wrongly loaded holding byte never shows on the count directly. It appears only on the next upper-byte read, or as a wrong high byte after the next lower-byte write, so the bench follows every such pair at once. A fault in the pin synchronizer moves each external step by a clock or counts it twice. The cycle-by-cycle comparison of count against the model exposes that at the edge it happens.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    SRC_STOP     = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } src_sel_e;

  localparam logic [2:0] A_CNT_LO = 3'd0;
  localparam logic [2:0] A_CNT_HI = 3'd1;
  localparam logic [2:0] A_CMP_LO = 3'd2;
  localparam logic [2:0] A_CMP_HI = 3'd3;
  localparam logic [2:0] A_CAP_LO = 3'd4;
  localparam logic [2:0] A_CAP_HI = 3'd5;

  localparam int NUM_TAPS = 5;

  // number of divider low bits that must all be ones for tap i
  function automatic int tap_shift(input int i);
    case (i)
      0: return 0;
      1: return 3;
      2: return 6;
      3: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic is_hi_addr(input logic [2:0] a);
    return (a == A_CNT_HI) || (a == A_CMP_HI) || (a == A_CAP_HI);
  endfunction

  function automatic logic [15:0] join_bytes(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic is_top(input logic [15:0] v);
    return &v;
  endfunction

endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler
  import tmr16_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_sel,
  input  logic       pin_rise,
  input  logic       pin_fall,
  output logic       step
);

  logic [DIV_W-1:0]    div_q;
  logic [NUM_TAPS-1:0] tap;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int SH = tap_shift(i);
    if (SH == 0) begin : g_full
      assign tap[i] = 1'b1;
    end else begin : g_div
      assign tap[i] = &div_q[SH-1:0];
    end
  end

  always_comb begin
    src_sel_e s;
    s = src_sel_e'(src_sel);
    case (s)
      SRC_STOP:     step = 1'b0;
      SRC_DIV1:     step = tap[0];
      SRC_DIV8:     step = tap[1];
      SRC_DIV64:    step = tap[2];
      SRC_DIV256:   step = tap[3];
      SRC_DIV1024:  step = tap[4];
      SRC_PIN_FALL: step = pin_fall;
      SRC_PIN_RISE: step = pin_rise;
      default:      step = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr16_edge_det.sv
module tmr16_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], pin_async};
  end

  assign rise =  pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign fall = ~pipe_q[SYNC_STAGES-1] &  pipe_q[SYNC_STAGES];

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic wrap;
  assign wrap = step && !load && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= wrap;
      if (load)      cnt <= load_val;
      else if (step) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tmr16_bridge.sv
module tmr16_bridge
  import tmr16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] cnt,
  input  logic [15:0] cap_val,
  output logic        cnt_load,
  output logic [15:0] cnt_load_val,
  output logic [15:0] cmp_q,
  output logic [7:0]  temp_q
);

  logic cmp_load;

  assign cnt_load     = bus_wr && (bus_addr == A_CNT_LO);
  assign cmp_load     = bus_wr && (bus_addr == A_CMP_LO);
  assign cnt_load_val = join_bytes(temp_q, bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (cmp_load) cmp_q <= join_bytes(temp_q, bus_wdata);
      if (bus_wr && is_hi_addr(bus_addr)) begin
        temp_q <= bus_wdata;
      end else if (bus_rd) begin
        case (bus_addr)
          A_CNT_LO: temp_q <= cnt[15:8];
          A_CMP_LO: temp_q <= cmp_q[15:8];
          A_CAP_LO: temp_q <= cap_val[15:8];
          default:  temp_q <= temp_q;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CNT_LO: bus_rdata = cnt[7:0];
        A_CMP_LO: bus_rdata = cmp_q[7:0];
        A_CAP_LO: bus_rdata = cap_val[7:0];
        A_CNT_HI, A_CMP_HI, A_CAP_HI: bus_rdata = temp_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  src_sel,
  input  logic        ext_pin,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] cap_val,
  output logic [15:0] count,
  output logic [15:0] cmp_val,
  output logic        ovf_pulse
);

  logic        pin_rise;
  logic        pin_fall;
  logic        cnt_step;
  logic        cnt_load;
  logic [15:0] cnt_load_val;
  logic [7:0]  temp_q;

  tmr16_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
    .rise(pin_rise), .fall(pin_fall)
  );

  tmr16_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .pin_rise(pin_rise), .pin_fall(pin_fall), .step(cnt_step)
  );

  tmr16_counter #(.CNT_W(16)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .load(cnt_load),
    .load_val(cnt_load_val), .cnt(count), .ovf(ovf_pulse)
  );

  tmr16_bridge u_br (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(count), .cap_val(cap_val), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .cmp_q(cmp_val), .temp_q(temp_q)
  );

endmodule

// File: rtl/tmr16_check.sv
module tmr16_check (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  src_sel,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [15:0] count,
  input logic [15:0] cmp_val,
  input logic        ovf_pulse,
  input logic        cnt_step,
  input logic [7:0]  temp_q
);

  // R2: halted source keeps the count unless the CPU loads it
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd0 && !(bus_wr && bus_addr == 3'd0)) |=> $stable(count));

  // R3: without a load the count either holds or moves up by one
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd0) |=>
      (count == $past(count) || count == $past(count) + 16'd1));

  // R5: an upper-byte write leaves the compare value alone
  a_r5_hi_write_keeps_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> $stable(cmp_val));

  // R6 and R9: a low-byte load commits holding byte plus data, even against a step
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && cnt_step) |=>
      count == {$past(temp_q), $past(bus_wdata)});

  // R7: a low-byte counter read freezes the counter high byte
  a_r7_freeze_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd0) |=> temp_q == $past(count[15:8]));

  // R10: the overflow pulse coincides with a zero count and lasts one cycle
  a_r10_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> count == 16'd0);

  a_r10_ovf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

endmodule

bind tmr16_core tmr16_check u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .count(count),
  .cmp_val(cmp_val), .ovf_pulse(ovf_pulse), .cnt_step(cnt_step),
  .temp_q(temp_q)
);

// File: tb/tmr16_core_test.sv
`timescale 1ns/1ps
module tmr16_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_sel = 3'd0;
  logic        ext_pin = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [15:0] cap_val = 16'd0;
  logic [15:0] count;
  logic [15:0] cmp_val;
  logic        ovf_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr16_core uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_pin(ext_pin),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_val(cap_val),
    .count(count), .cmp_val(cmp_val), .ovf_pulse(ovf_pulse)
  );

  // ---------------- reference model, written from the requirements
  logic [9:0]  m_div;
  logic [2:0]  m_pin;
  logic [15:0] m_cnt;
  logic [15:0] m_cmp;
  logic [7:0]  m_tmp;
  logic        m_ovf;

  function automatic bit rate_hit(input logic [2:0] s, input logic [9:0] d);
    case (s)
      3'd1: return 1'b1;
      3'd2: return d[2:0] == 3'b111;
      3'd3: return d[5:0] == 6'h3F;
      3'd4: return d[7:0] == 8'hFF;
      3'd5: return d == 10'h3FF;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit step_now(input logic [2:0] s, input logic [9:0] d,
                                  input logic [2:0] p);
    if (s == 3'd7) return p[1] && !p[2];
    if (s == 3'd6) return !p[1] && p[2];
    return rate_hit(s, d);
  endfunction

  function automatic logic [7:0] exp_rdata(input bit rd, input logic [2:0] a);
    if (!rd) return 8'h00;
    case (a)
      3'd0: return m_cnt[7:0];
      3'd2: return m_cmp[7:0];
      3'd4: return cap_val[7:0];
      3'd1, 3'd3, 3'd5: return m_tmp;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div <= '0; m_pin <= '0; m_cnt <= '0; m_cmp <= '0; m_tmp <= '0; m_ovf <= 1'b0;
    end else begin
      bit st, ld;
      st = step_now(src_sel, m_div, m_pin);
      ld = bus_wr && bus_addr == 3'd0;
      m_div <= m_div + 10'd1;
      m_pin <= {m_pin[1:0], ext_pin};
      m_ovf <= st && !ld && m_cnt == 16'hFFFF;
      if (ld) m_cnt <= {m_tmp, bus_wdata};
      else if (st) m_cnt <= m_cnt + 16'd1;
      if (bus_wr && bus_addr == 3'd2) m_cmp <= {m_tmp, bus_wdata};
      if (bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd3 || bus_addr == 3'd5))
        m_tmp <= bus_wdata;
      else if (bus_rd && bus_addr == 3'd0) m_tmp <= m_cnt[15:8];
      else if (bus_rd && bus_addr == 3'd2) m_tmp <= m_cmp[15:8];
      else if (bus_rd && bus_addr == 3'd4) m_tmp <= cap_val[15:8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every cycle: compare the state outputs against the model, mid-cycle
  task automatic cmp_state(input string req);
    chk(req, {16'd0, count}, {16'd0, m_cnt});
    chk(req, {31'd0, ovf_pulse}, {31'd0, m_ovf});
    chk(req, {16'd0, cmp_val}, {16'd0, m_cmp});
  endtask

  // one bus cycle: drive at negedge, check rdata, let one edge pass
  task automatic cyc(input string req, input bit wr, input bit rd,
                     input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cmp_state(req);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #0.5;
    if (rd) chk(req, {24'd0, bus_rdata}, {24'd0, exp_rdata(rd, a)});
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic wr16(input string req, input logic [2:0] lo, input logic [15:0] v);
    cyc(req, 1'b1, 1'b0, lo + 3'd1, v[15:8]);
    cyc(req, 1'b1, 1'b0, lo, v[7:0]);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    @(negedge clk);
    chk("R1 count", {16'd0, count}, 32'd0);
    chk("R1 cmp", {16'd0, cmp_val}, 32'd0);
    chk("R1 ovf", {31'd0, ovf_pulse}, 32'd0);
    bus_rd = 1'b1; bus_addr = 3'd1; #0.5;
    chk("R1 temp", {24'd0, bus_rdata}, 32'd0);
    bus_rd = 1'b0;

    // R2: stopped
    src_sel = 3'd0;
    idle("R2", 20);
    chk("R2 held", {16'd0, count}, 32'd0);

    // R5: high write touches only holding byte
    cyc("R5", 1'b1, 1'b0, 3'd1, 8'hAB);
    idle("R5", 2);
    chk("R5 count", {16'd0, count}, 32'd0);
    cyc("R5", 1'b0, 1'b1, 3'd1, 8'h00);
    chk("R5 temp", {24'd0, bus_rdata}, 32'h000000AB);

    // R6: atomic loads, and ignored addresses
    wr16("R6", 3'd0, 16'h1234);
    wr16("R6", 3'd2, 16'hBEEF);
    cyc("R6", 1'b1, 1'b0, 3'd6, 8'h55);
    cyc("R6", 1'b1, 1'b0, 3'd4, 8'h66);
    idle("R6", 1);
    chk("R6 count", {16'd0, count}, 32'h1234);
    chk("R6 cmp", {16'd0, cmp_val}, 32'hBEEF);

    // R10: wrap with the undivided clock
    wr16("R10", 3'd0, 16'hFFFD);
    src_sel = 3'd1;
    idle("R10", 6);
    src_sel = 3'd0;
    idle("R10", 1);

    // R9: load in same cycle as a step
    src_sel = 3'd1;
    wr16("R9", 3'd0, 16'h0F00);
    idle("R9", 1);
    src_sel = 3'd0;

    // R7 and R8: frozen high byte, shared holding byte
    cap_val = 16'hC3A5;
    wr16("R8", 3'd0, 16'h12FE);
    src_sel = 3'd1;
    cyc("R7", 1'b0, 1'b1, 3'd0, 8'h00);
    idle("R7", 4);
    cyc("R8", 1'b0, 1'b1, 3'd3, 8'h00);
    chk("R8 shared temp", {24'd0, bus_rdata}, 32'h00000012);
    src_sel = 3'd0;
    cyc("R7", 1'b0, 1'b1, 3'd4, 8'h00);
    cyc("R7", 1'b0, 1'b1, 3'd5, 8'h00);
    chk("R7 capture hi", {24'd0, bus_rdata}, 32'h000000C3);
    cyc("R7", 1'b0, 1'b1, 3'd7, 8'h00);

    // R3: each divided rate
    for (int s = 1; s <= 5; s++) begin
      wr16("R3", 3'd0, 16'h0000);
      src_sel = 3'(s);
      idle("R3", 2100);
      src_sel = 3'd0;
    end

    // R4: external pin edges, both polarities
    for (int s = 6; s <= 7; s++) begin
      src_sel = 3'(s);
      for (int k = 0; k < 20; k++) begin
        ext_pin = ~ext_pin;
        idle("R4", 1 + (k % 4));
      end
    end
    src_sel = 3'd0;

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) src_sel = 3'($urandom_range(0, 7));
      if (r < 30) ext_pin = ~ext_pin;
      if (r % 7 == 0) cap_val = 16'($urandom);
      if (r < 25)
        cyc("R6 rand", 1'b1, 1'b0, 3'($urandom_range(0, 7)), 8'($urandom));
      else if (r < 50)
        cyc("R7 rand", 1'b0, 1'b1, 3'($urandom_range(0, 7)), 8'h00);
      else
        idle("R3 rand", 1);
      if (i % 1500 == 0) wr16("R10 rand", 3'd0, 16'hFFF8);
    end
    idle("R10", 2);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    done = 1'b1;
    $finish;
  end

endmodule